// File: doc/BRIEF.md
# Host Mailbox Boot Release

This block keeps a processor parked in a boot wait loop while an external host fills local memory with a program image. The host reaches a small word-addressed RAM through a simple write/read port. Two words at fixed word addresses form a mailbox. The upper byte of the high mailbox word is a wait flag. The remaining 24 bits hold the byte address where execution starts. While the flag is zero the block keeps waiting. Once the flag becomes non-zero it issues a one-clock start pulse and latches the 24-bit start address.

The start address is a byte address, while host addresses are word addresses. Code that should run from byte address 2000h is therefore loaded at word address 1000h. The host must write the low mailbox word first, because release follows the flag write at once. A warm reset clears the mailbox and keeps the RAM image. After a warm reset the host only rewrites the two mailbox words to boot again.

Top module: `boot_mailbox`

## Requirements
- R1: While rst_ni is low, ready_no_o is 1, start_o is 0 and start_addr_o is 0. After reset both mailbox words read back as 0.
- R2: ready_no_o goes low on the first rising clock edge after rst_ni is released. It stays low until release.
- R3: A read request returns data one cycle later. For any word address other than the mailbox this is the last word written there. At word addresses 0x60 and 0x61 it is the current high and low mailbox word.
- R4: While bits 15:8 of the high mailbox word (word 0x60) are zero, start_o stays 0 and ready_no_o stays low, whatever values are written.
- R5: One clock after the write that makes bits 15:8 of word 0x60 non-zero, start_o is 1 for exactly one cycle. At that point start_addr_o = {word 0x60 bits 7:0, word 0x61}.
- R6: Release uses the low word held when the flag is seen. If the high word is written first, the start address carries the old low word, and a later low-word write does not alter it.
- R7: After release, ready_no_o is 1 and start_addr_o holds its value until the next reset. No further start pulse occurs.
- R8: Host writes to words 0x60 and 0x61 after release are ignored, and read-back still returns the released values.
- R9: A reset leaves the RAM image intact and clears the mailbox. Rewriting the mailbox then boots again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| host_we_i | input | 1 | Host write strobe |
| host_re_i | input | 1 | Host read strobe |
| host_addr_i | input | AW | Host word address |
| host_wdata_i | input | 16 | Host write data |
| host_rdata_o | output | 16 | Host read data, valid one cycle after host_re_i |
| ready_no_o | output | 1 | Low while waiting for the host |
| start_o | output | 1 | One-cycle release pulse |
| start_addr_o | output | 24 | Latched byte start address |

## Verification
A mailbox write lands on the clock edge of its write cycle. The release logic sees the new flag at the following edge, so start_o and start_addr_o are due one cycle after the write edge. start_o drops one cycle after that. Read data is due on the edge after the read strobe. ready_no_o falls at the first edge after reset is released. The bench drives inputs at falling edges and samples at the falling edge that follows each due rising edge. It checks start_o as 0 at the write edge, as 1 one edge later, and as 0 again after that. A falling-edge monitor counts every start pulse, which catches stray releases.

// File: rtl/boot_mbox_pkg.sv
package boot_mbox_pkg;
  localparam int DW     = 16;
  localparam int FLAG_W = 8;
  localparam int SA_W   = 24;

  typedef enum logic [1:0] {
    S_INIT = 2'd0,
    S_WAIT = 2'd1,
    S_RUN  = 2'd2
  } mbox_state_e;
endpackage

// File: rtl/mbox_ram.sv
module mbox_ram #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic          re_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  // no reset: image survives warm reset
  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= wdata_i;
    if (re_i) rdata_o <= mem_q[addr_i];
  end
endmodule

// File: rtl/mbox_regs.sv
module mbox_regs
  import boot_mbox_pkg::*;
#(
  parameter int AW      = 8,
  parameter int HI_ADDR = 'h60
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          open_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] hi_o,
  output logic [DW-1:0] lo_o
);
  localparam logic [AW-1:0] HI_A = AW'(HI_ADDR);
  localparam logic [AW-1:0] LO_A = AW'(HI_ADDR + 1);

  logic hi_wr, lo_wr;
  assign hi_wr = open_i && we_i && (addr_i == HI_A);
  assign lo_wr = open_i && we_i && (addr_i == LO_A);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_o <= '0;
      lo_o <= '0;
    end else begin
      if (hi_wr) hi_o <= wdata_i;
      if (lo_wr) lo_o <= wdata_i;
    end
  end

  // R8
  locked_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !open_i |=> ($stable(hi_o) && $stable(lo_o)));
endmodule

// File: rtl/mbox_release_fsm.sv
module mbox_release_fsm
  import boot_mbox_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [DW-1:0]   hi_i,
  input  logic [DW-1:0]   lo_i,
  output logic            waiting_o,
  output logic            start_o,
  output logic [SA_W-1:0] start_addr_o
);
  mbox_state_e       state_q;
  logic [FLAG_W-1:0] flag;

  assign flag      = hi_i[DW-1:DW-FLAG_W];
  assign waiting_o = (state_q == S_WAIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= S_INIT;
      start_o      <= 1'b0;
      start_addr_o <= '0;
    end else begin
      start_o <= 1'b0;
      unique case (state_q)
        S_INIT: state_q <= S_WAIT;
        S_WAIT: if (flag != '0) begin
          state_q      <= S_RUN;
          start_o      <= 1'b1;
          start_addr_o <= {hi_i[DW-FLAG_W-1:0], lo_i};
        end
        default: state_q <= S_RUN;
      endcase
    end
  end

  // R5
  start_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o);
  // R4
  flag_zero_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (waiting_o && flag == '0) |=> !start_o);
  // R7
  addr_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_RUN && !start_o) |-> $stable(start_addr_o));
endmodule

// File: rtl/boot_mailbox.sv
module boot_mailbox
  import boot_mbox_pkg::*;
#(
  parameter int AW      = 8,
  parameter int HI_ADDR = 'h60
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            host_we_i,
  input  logic            host_re_i,
  input  logic [AW-1:0]   host_addr_i,
  input  logic [DW-1:0]   host_wdata_i,
  output logic [DW-1:0]   host_rdata_o,
  output logic            ready_no_o,
  output logic            start_o,
  output logic [SA_W-1:0] start_addr_o
);
  localparam logic [AW-1:0] HI_A = AW'(HI_ADDR);
  localparam logic [AW-1:0] LO_A = AW'(HI_ADDR + 1);

  logic          waiting;
  logic [DW-1:0] hi, lo, ram_q, mbox_q;
  logic          mbox_sel_q;

  mbox_ram #(.AW(AW), .DW(DW)) u_ram (
    .clk_i  (clk_i),
    .we_i   (host_we_i),
    .re_i   (host_re_i),
    .addr_i (host_addr_i),
    .wdata_i(host_wdata_i),
    .rdata_o(ram_q)
  );

  mbox_regs #(.AW(AW), .HI_ADDR(HI_ADDR)) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .open_i (waiting),
    .we_i   (host_we_i),
    .addr_i (host_addr_i),
    .wdata_i(host_wdata_i),
    .hi_o   (hi),
    .lo_o   (lo)
  );

  mbox_release_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .hi_i        (hi),
    .lo_i        (lo),
    .waiting_o   (waiting),
    .start_o     (start_o),
    .start_addr_o(start_addr_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mbox_sel_q <= 1'b0;
      mbox_q     <= '0;
    end else if (host_re_i) begin
      mbox_sel_q <= (host_addr_i == HI_A) || (host_addr_i == LO_A);
      mbox_q     <= (host_addr_i == HI_A) ? hi : lo;
    end
  end

  assign host_rdata_o = mbox_sel_q ? mbox_q : ram_q;
  assign ready_no_o   = !waiting;

  // R7
  ready_after_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> ready_no_o);
endmodule

// File: tb/tb_boot_mailbox.sv
module tb_boot_mailbox;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        host_we_i = 1'b0;
  logic        host_re_i = 1'b0;
  logic [7:0]  host_addr_i = '0;
  logic [15:0] host_wdata_i = '0;
  logic [15:0] host_rdata_o;
  logic        ready_no_o;
  logic        start_o;
  logic [23:0] start_addr_o;

  int checks = 0;
  int errors = 0;
  int pulses = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  boot_mailbox dut (.*);

  always @(negedge clk_i) if (start_o) pulses++;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [15:0] d);
    @(negedge clk_i);
    host_we_i = 1'b1; host_addr_i = a; host_wdata_i = d;
    @(negedge clk_i);
    host_we_i = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [15:0] d);
    @(negedge clk_i);
    host_re_i = 1'b1; host_addr_i = a;
    @(negedge clk_i);
    host_re_i = 1'b0;
    d = host_rdata_o;
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    chk("R1 ready_no", 32'(ready_no_o), 1);
    chk("R1 start", 32'(start_o), 0);
    chk("R1 addr", 32'(start_addr_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    chk("R2 ready_no before edge", 32'(ready_no_o), 1);
    @(negedge clk_i);
    chk("R2 ready_no low", 32'(ready_no_o), 0);
    pulses = 0;
  endtask

  task automatic t_ram();
    logic [15:0] d;
    wr(8'h10, 16'hA5C3);
    wr(8'hFF, 16'h1234);
    wr(8'h00, 16'hFFFF);
    rd(8'h10, d); chk("R3 ram 10", 32'(d), 32'hA5C3);
    rd(8'hFF, d); chk("R3 ram ff", 32'(d), 32'h1234);
    rd(8'h00, d); chk("R3 ram 00", 32'(d), 32'hFFFF);
    rd(8'h60, d); chk("R1 mbox hi zero", 32'(d), 0);
    rd(8'h61, d); chk("R1 mbox lo zero", 32'(d), 0);
  endtask

  task automatic t_flag_zero();
    logic [15:0] d;
    wr(8'h61, 16'h2000);
    wr(8'h60, 16'h0012);
    repeat (4) @(negedge clk_i);
    chk("R4 no pulse", 32'(pulses), 0);
    chk("R4 ready_no", 32'(ready_no_o), 0);
    rd(8'h60, d); chk("R3 mbox hi read", 32'(d), 32'h0012);
    rd(8'h61, d); chk("R3 mbox lo read", 32'(d), 32'h2000);
  endtask

  task automatic t_release();
    wr(8'h60, 16'h8012);
    chk("R5 start at write edge", 32'(start_o), 0);
    @(negedge clk_i);
    chk("R5 start pulse", 32'(start_o), 1);
    chk("R5 start addr", 32'(start_addr_o), 32'h122000);
    chk("R7 ready_no high", 32'(ready_no_o), 1);
    @(negedge clk_i);
    chk("R5 pulse one cycle", 32'(start_o), 0);
  endtask

  task automatic t_locked();
    logic [15:0] d;
    wr(8'h61, 16'hFFFF);
    wr(8'h60, 16'hFFFF);
    repeat (3) @(negedge clk_i);
    rd(8'h60, d); chk("R8 hi ignored", 32'(d), 32'h8012);
    rd(8'h61, d); chk("R8 lo ignored", 32'(d), 32'h2000);
    chk("R7 addr stable", 32'(start_addr_o), 32'h122000);
    chk("R7 single pulse", 32'(pulses), 1);
    chk("R7 ready_no stays", 32'(ready_no_o), 1);
  endtask

  task automatic t_warm();
    logic [15:0] d;
    do_reset();
    rd(8'h10, d); chk("R9 image kept", 32'(d), 32'hA5C3);
    rd(8'h60, d); chk("R9 mbox cleared", 32'(d), 0);
    wr(8'h61, 16'h0ABC);
    wr(8'h60, 16'h0101);
    @(negedge clk_i);
    chk("R9 reboot pulse", 32'(start_o), 1);
    chk("R9 reboot addr", 32'(start_addr_o), 32'h010ABC);
  endtask

  task automatic t_order();
    do_reset();
    wr(8'h60, 16'h0534);
    @(negedge clk_i);
    chk("R6 early release", 32'(start_o), 1);
    chk("R6 stale low word", 32'(start_addr_o), 32'h340000);
    wr(8'h61, 16'h7777);
    repeat (2) @(negedge clk_i);
    chk("R6 late low ignored", 32'(start_addr_o), 32'h340000);
    chk("R6 one pulse", 32'(pulses), 1);
  endtask

  initial begin
    do_reset();
    t_ram();
    t_flag_zero();
    t_release();
    t_locked();
    t_warm();
    t_order();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule